// File: doc/BRIEF.md
# 1-Wire Search Triplet Engine

This block carries out one step of a 1-Wire ROM search as a single command. In triplet mode it runs three time slots back to back. The first two are read slots: the master writes a 1 and samples the line to obtain a device ID bit, then does the same to obtain its complement. The third is a write slot, and the value it writes is the search direction. That direction is derived from the two sampled bits and a preferred direction supplied by the host. The block stores both sampled bits and the chosen direction in result flags. It holds `busy` high from the start of the first slot to the end of the last.

In single-bit mode the block runs one slot only, which is either a write-1/read slot or a write-0 slot. Only the first result flag is updated. Every slot begins with a short low pulse. A write-0 holds the line low for longer. The line is sampled at a fixed count into the slot, and a short recovery time with the line released follows each slot. All of these durations are clock-count parameters. The bus itself is open drain: `line_drive_low` pulls the line low, and `line_in` returns the level read back from the wire.

Top module: `owt_triplet_engine`

## Requirements
- R1: After reset `busy`, `line_drive_low`, `res_first`, `res_second` and `res_dir` are all 0.
- R2: A triplet command keeps `busy` high for exactly 3*(SLOT_CYC+REC_CYC) cycles. A single-bit command keeps it high for exactly SLOT_CYC+REC_CYC cycles. `line_drive_low` is never 1 while `busy` is 0.
- R3: `res_first` takes the `line_in` level sampled SAMPLE_CYC cycles into the first slot. The first slot of a triplet is a write-1 slot, which drives the line low for LOW_CYC cycles.
- R4: `res_second` takes the level sampled in the second slot of a triplet. A single-bit command leaves it unchanged.
- R5: The value written in the third slot is chosen as follows. When the two sampled bits differ, it is the first bit. When both bits are 0, it is `cmd_wbit`. When both bits are 1, it is 1.
- R6: `res_dir` holds the value written in the third slot. A 1 drives the line low for LOW_CYC cycles and a 0 for W0_CYC cycles. A single-bit command leaves `res_dir` unchanged.
- R7: A single-bit command with `cmd_wbit`=0 drives the line low for W0_CYC cycles and leaves `res_first` at 0. With `cmd_wbit`=1 it behaves as a read slot.
- R8: Each slot is followed by at least REC_CYC cycles with the line released, and the next slot then starts at once.
- R9: A `cmd_valid` pulse that arrives while `busy` is high is ignored. Neither the busy length nor the slots change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a command (taken only while idle) |
| cmd_triplet | input | 1 | 1 = triplet, 0 = single bit |
| cmd_wbit | input | 1 | Single bit: value to write; triplet: preferred direction |
| line_in | input | 1 | Level read back from the bus |
| line_drive_low | output | 1 | 1 pulls the bus low |
| busy | output | 1 | Command in progress |
| res_first | output | 1 | First sampled bit |
| res_second | output | 1 | Second sampled bit (triplet only) |
| res_dir | output | 1 | Direction written in the third slot |

## Verification
A modelled device pulls the line low during chosen read slots. The bench runs all four combinations of ID and complement bits, each with both preferred directions. This separates the discrepancy case, the case where both bits are 0 and the host preference decides, and the case where both are 1 with no device present. Single-bit commands with both write values are interleaved with triplets. Their effect on the untouched result flags distinguishes triplet-only updates from accidental ones. Random sequences mix both modes. A stray request is injected while a command is busy.

// File: rtl/owt_pkg.sv
`timescale 1ns/1ps
package owt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ID,
        ST_CMP,
        ST_DIR
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic wbit;
    } slot_req_t;

    typedef struct packed {
        logic first;
        logic second;
        logic dir;
    } result_t;

    // Direction chosen from ID bit, complement bit and host preference.
    function automatic logic pick_dir(logic id_bit, logic cmp_bit, logic pref);
        if (id_bit != cmp_bit) return id_bit;
        else if (!id_bit)      return pref;
        else                   return 1'b1;
    endfunction

endpackage

// File: rtl/owt_slot_timer.sv
`timescale 1ns/1ps
module owt_slot_timer
    import owt_pkg::*;
#(
    parameter int LOW_CYC    = 750,
    parameter int W0_CYC     = 7500,
    parameter int SAMPLE_CYC = 1875,
    parameter int SLOT_CYC   = 8750,
    parameter int REC_CYC    = 125
) (
    input  logic      clk,
    input  logic      rst,
    input  slot_req_t req,
    output logic      drive_low,
    output logic      sample_stb,
    output logic      done
);
    localparam int TOTAL = SLOT_CYC + REC_CYC;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LAST   = CW'(TOTAL - 1);
    localparam logic [CW-1:0] LOW_C  = CW'(LOW_CYC);
    localparam logic [CW-1:0] W0_C   = CW'(W0_CYC);
    localparam logic [CW-1:0] SAMP_C = CW'(SAMPLE_CYC);

    logic          active;
    logic          wb;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            wb     <= 1'b1;
        end else if (req.start) begin
            active <= 1'b1;
            cnt    <= '0;
            wb     <= req.wbit;
        end else if (active) begin
            if (cnt == LAST) active <= 1'b0;
            else             cnt    <= cnt + 1'b1;
        end
    end

    always_comb begin
        drive_low  = active && ((cnt < LOW_C) || (!wb && (cnt < W0_C)));
        sample_stb = active && (cnt == SAMP_C);
        done       = active && (cnt == LAST);
    end
endmodule

// File: rtl/owt_sequencer.sv
`timescale 1ns/1ps
module owt_sequencer
    import owt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  logic      cmd_triplet,
    input  logic      cmd_wbit,
    input  logic      line_in,
    input  logic      sample_stb,
    input  logic      slot_done,
    output slot_req_t req,
    output logic      busy,
    output logic      is_triplet,
    output result_t   res
);
    seq_state_e state, state_n;
    logic       pref;
    logic       wbit_l;

    always_comb begin
        req     = '0;
        state_n = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) begin
                req.start = 1'b1;
                req.wbit  = cmd_triplet ? 1'b1 : cmd_wbit;
                state_n   = ST_ID;
            end
            ST_ID: if (slot_done) begin
                if (is_triplet) begin
                    req.start = 1'b1;
                    req.wbit  = 1'b1;
                    state_n   = ST_CMP;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            ST_CMP: if (slot_done) begin
                req.start = 1'b1;
                req.wbit  = pick_dir(res.first, res.second, pref);
                state_n   = ST_DIR;
            end
            ST_DIR: if (slot_done) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            is_triplet <= 1'b0;
            pref       <= 1'b0;
            wbit_l     <= 1'b1;
            res        <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && cmd_valid) begin
                is_triplet <= cmd_triplet;
                pref       <= cmd_wbit;
                wbit_l     <= req.wbit;
            end
            if (state == ST_ID && sample_stb)
                res.first <= line_in & wbit_l;
            if (state == ST_CMP && sample_stb)
                res.second <= line_in;
            if (state == ST_CMP && slot_done)
                res.dir <= req.wbit;
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/owt_triplet_engine.sv
`timescale 1ns/1ps
module owt_triplet_engine
    import owt_pkg::*;
#(
    parameter int LOW_CYC    = 750,
    parameter int W0_CYC     = 7500,
    parameter int SAMPLE_CYC = 1875,
    parameter int SLOT_CYC   = 8750,
    parameter int REC_CYC    = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic cmd_triplet,
    input  logic cmd_wbit,
    input  logic line_in,
    output logic line_drive_low,
    output logic busy,
    output logic res_first,
    output logic res_second,
    output logic res_dir
);
    slot_req_t req;
    result_t   res;
    logic      sample_stb;
    logic      slot_done;
    logic      is_triplet;

    owt_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_triplet(cmd_triplet),
        .cmd_wbit   (cmd_wbit),
        .line_in    (line_in),
        .sample_stb (sample_stb),
        .slot_done  (slot_done),
        .req        (req),
        .busy       (busy),
        .is_triplet (is_triplet),
        .res        (res)
    );

    owt_slot_timer #(
        .LOW_CYC   (LOW_CYC),
        .W0_CYC    (W0_CYC),
        .SAMPLE_CYC(SAMPLE_CYC),
        .SLOT_CYC  (SLOT_CYC),
        .REC_CYC   (REC_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .drive_low (line_drive_low),
        .sample_stb(sample_stb),
        .done      (slot_done)
    );

    assign res_first  = res.first;
    assign res_second = res.second;
    assign res_dir    = res.dir;
endmodule

// File: rtl/owt_triplet_checker.sv
`timescale 1ns/1ps
module owt_triplet_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic line_drive_low,
    input logic is_triplet,
    input logic res_first,
    input logic res_second,
    input logic res_dir
);
    p_drive_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
        line_drive_low |-> busy);

    p_first_changes_busy_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(res_first) |-> $past(busy));

    p_second_single_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_triplet) |=> $stable(res_second));

    p_dir_single_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_triplet) |=> $stable(res_dir));

    p_dir_rule_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && is_triplet && (res_first != res_second)) |-> (res_dir == res_first));

    p_dir_none_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && is_triplet && res_first && res_second) |-> res_dir);
endmodule

bind owt_triplet_engine owt_triplet_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .line_drive_low(line_drive_low),
    .is_triplet    (is_triplet),
    .res_first     (res_first),
    .res_second    (res_second),
    .res_dir       (res_dir)
);

// File: tb/owt_triplet_engine_bench.sv
`timescale 1ns/1ps
module owt_triplet_engine_bench;
    localparam int LOW   = 3;
    localparam int W0    = 20;
    localparam int SAMP  = 8;
    localparam int SLOT  = 25;
    localparam int REC   = 2;
    localparam int TOTAL = SLOT + REC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_triplet = 1'b0;
    logic cmd_wbit = 1'b0;
    logic line_in = 1'b1;
    logic line_drive_low, busy, res_first, res_second, res_dir;

    int n_tests = 0;
    int n_fail  = 0;
    logic e_first = 1'b0, e_second = 1'b0, e_dir = 1'b0;

    always #4 clk = ~clk;

    owt_triplet_engine #(
        .LOW_CYC(LOW), .W0_CYC(W0), .SAMPLE_CYC(SAMP), .SLOT_CYC(SLOT), .REC_CYC(REC)
    ) u_owt_triplet_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_triplet(cmd_triplet),
        .cmd_wbit(cmd_wbit), .line_in(line_in), .line_drive_low(line_drive_low),
        .busy(busy), .res_first(res_first), .res_second(res_second), .res_dir(res_dir)
    );

    function automatic logic exp_dir(logic a, logic b, logic pref);
        if (a ^ b) return a;
        if (a)     return 1'b1;
        return pref;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // p0/p1: device pulls line low during slot 1 / slot 2
    task automatic run_cmd(input logic trip, input logic wb, input logic p0,
                           input logic p1, input bit poke);
        int idx = 0;
        int bcnt = 0;
        int cyc = 0;
        int lows[4] = '{0, 0, 0, 0};
        logic prev = 1'b0;
        logic pull;
        logic wdir;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_triplet = trip; cmd_wbit = wb;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy && cyc < 1000) begin
            if (line_drive_low && !prev) idx++;
            if (line_drive_low && idx >= 1 && idx <= 3) lows[idx]++;
            pull = (idx == 1 && p0) || (idx == 2 && p1);
            line_in = !(line_drive_low || pull);
            bcnt++;
            prev = line_drive_low;
            cyc++;
            if (poke && cyc == 10) cmd_valid = 1'b1;
            if (cyc == 11) cmd_valid = 1'b0;
            @(negedge clk);
        end
        line_in = 1'b1;
        if (trip) begin
            e_first  = !p0;
            e_second = !p1;
            e_dir    = exp_dir(e_first, e_second, wb);
        end else begin
            e_first = wb ? !p0 : 1'b0;
        end
        wdir = e_dir;
        chk(bcnt == (trip ? 3 * TOTAL : TOTAL), "R2 busy length", bcnt, trip ? 3 * TOTAL : TOTAL);
        chk(res_first == e_first, "R3 res_first", res_first, e_first);
        chk(res_second == e_second, "R4 res_second", res_second, e_second);
        chk(res_dir == e_dir, "R5 R6 res_dir", res_dir, e_dir);
        if (trip) begin
            chk(lows[1] == LOW, "R3 first slot low", lows[1], LOW);
            chk(lows[2] == LOW, "R8 second slot low", lows[2], LOW);
            chk(lows[3] == (wdir ? LOW : W0), "R6 third slot low", lows[3], wdir ? LOW : W0);
        end else begin
            chk(lows[1] == (wb ? LOW : W0), "R7 single slot low", lows[1], wb ? LOW : W0);
            chk(idx == 1, "R7 single slot count", idx, 1);
        end
        if (poke) begin
            @(negedge clk);
            chk(busy == 1'b0, "R9 busy after ignored request", busy, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0102));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(line_drive_low == 0, "R1 drive", line_drive_low, 0);
        chk(res_first == 0, "R1 res_first", res_first, 0);
        chk(res_second == 0, "R1 res_second", res_second, 0);
        chk(res_dir == 0, "R1 res_dir", res_dir, 0);

        // Directed: every bit pair with both preferences (R5)
        for (int k = 0; k < 8; k++) begin
            run_cmd(1'b1, k[2], k[0], k[1], 1'b0);
        end
        // Single-bit commands keep second/dir (R4, R6, R7)
        run_cmd(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        run_cmd(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_cmd(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        // Request during busy ignored (R9)
        run_cmd(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        run_cmd(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic t, w, a, b;
            t = ($urandom % 3) != 0;
            w = $urandom % 2;
            a = $urandom % 2;
            b = $urandom % 2;
            run_cmd(t, w, a, b, ($urandom % 8) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule